// File: doc/BRIEF.md
# Three-Phase Host Command Sequencer

This block sequences each host operation of a disk-controller-style command port through three phases. In the command phase the host writes an opcode byte and then a fixed number of parameter bytes. In the execution phase a counted run of data bytes is moved, one request per byte. In the optional result phase the host reads status bytes back. A status byte tells the host when a byte may move and in which direction. The host therefore polls that byte and moves data one byte at a time.

A small table indexed by the opcode gives the parameter count, whether an execution run follows, and how many result bytes are returned. Execution is modelled as a counted transfer. The second parameter byte gives the number of data bytes. Each byte is signalled either on an interrupt line or on a DMA request line, and an acknowledge input consumes it. A mode command chooses which of the two lines is used. Unknown opcodes take no parameters and return a single error byte.

Top module: `host_cmd_sequencer`

## Requirements
- R1: After reset the status byte is 0x80, the block waits for an opcode, and per-byte requests use the interrupt line.
- R2: The status byte layout is: bit 7 = ready for transfer, bit 6 = direction (1 means block to host), bit 5 = execution run active, bit 4 = busy. Bits 3..0 always read 0.
- R3: One cycle after each accepted command byte, the ready bit reads 0. One cycle later it reads 1 again if more parameter bytes are still expected.
- R4: The opcode table is as follows. 0x03 (mode) takes 2 parameters and returns no result. 0x04 (sense) takes 0 parameters and returns 2 result bytes: the opcode, then the mode bit in bit 0. 0x05 (write) takes 2 parameters, runs execution and returns no result. 0x06 (read) takes 2 parameters, runs execution and returns 3 result bytes: the opcode, parameter 1, parameter 2.
- R5: Once the last command byte has been taken, the block moves on by itself after a single gap cycle. It goes to execution, to results, or back to the command phase.
- R6: During execution the number of data bytes equals parameter 2, and a count of 0 skips execution. Exactly one request line is high while a byte is pending, and each cycle with the acknowledge input high consumes one byte.
- R7: Bit 0 of the mode command's second parameter selects the request line: 1 selects the interrupt line, 0 selects the DMA request line.
- R8: In the result phase the ready and direction bits are both 1 while a byte is readable, and the bytes come out in table order. After each read the ready bit is 0 for one cycle.
- R9: After the last result byte has been read, the block returns to the command phase with status 0x80.
- R10: Busy is 1 from the first accepted opcode until the last result byte has been read. For a command without results, it stays 1 until the end of execution.
- R11: A host write is ignored unless ready is 1 and direction is 0, and a read is ignored outside the result phase. The read data bus reads 0 whenever no result byte is offered.
- R12: An opcode not in the table takes no parameters and returns a single result byte 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| hostWrEn | input | 1 | Host writes a command byte this cycle |
| hostWrData | input | 8 | Command or parameter byte |
| hostRdEn | input | 1 | Host reads a result byte this cycle |
| hostRdData | output | 8 | Result byte offered to the host, 0 otherwise |
| statusOut | output | 8 | Main status byte (ready, direction, execution, busy) |
| irqOut | output | 1 | Per-byte request in interrupt mode |
| dmaReqOut | output | 1 | Per-byte request in DMA mode |
| xferAck | input | 1 | Consumes one pending execution byte |

## Verification
Most internal faults reach the status byte within one or two cycles. A wrong byte index or parameter count shows as a ready bit that returns when it should stay low, or that stays low when it should return, in the cycle after a write. A stale phase shows as wrong direction or execution bits. A faulty down-counter shows as an extra or missing request pulse before the result phase opens. A wrong mode bit shows as the other request line being raised on the first execution byte. A result index or multiplexer fault shows on the read data bus at the first read of the affected byte.

// File: rtl/hseq_pkg.sv
package hseq_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OP_MODE    = 8'h03;
  localparam logic [BYTE_W-1:0] OP_SENSE   = 8'h04;
  localparam logic [BYTE_W-1:0] OP_WRITE   = 8'h05;
  localparam logic [BYTE_W-1:0] OP_READ    = 8'h06;
  localparam logic [BYTE_W-1:0] BAD_OP_RES = 8'h80;

  typedef enum logic [2:0] {
    S_CMD, S_CMD_GAP, S_EXEC, S_RES, S_RES_GAP
  } phase_e;

  typedef struct packed {
    logic       valid;
    logic [1:0] nParams;
    logic       hasExec;
    logic [1:0] resLen;
    logic       isMode;
    logic       isSense;
  } cmd_info_t;

  // control -> datapath strobes
  typedef struct packed {
    logic capByte;
    logic cmdDone;
    logic decRem;
    logic resAdv;
  } strobe_t;

  function automatic cmd_info_t decodeOp(input logic [BYTE_W-1:0] op);
    cmd_info_t d;
    d = '0;
    case (op)
      OP_MODE:  begin d.valid = 1'b1; d.nParams = 2'd2; d.isMode = 1'b1; end
      OP_SENSE: begin d.valid = 1'b1; d.resLen = 2'd2; d.isSense = 1'b1; end
      OP_WRITE: begin d.valid = 1'b1; d.nParams = 2'd2; d.hasExec = 1'b1; end
      OP_READ:  begin d.valid = 1'b1; d.nParams = 2'd2; d.hasExec = 1'b1; d.resLen = 2'd3; end
      default:  begin d.resLen = 2'd1; end
    endcase
    return d;
  endfunction
endpackage

// File: rtl/hseq_dpath.sv
module hseq_dpath
  import hseq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [BYTE_W-1:0] wrData,
  output logic              allIn,
  output logic              execNeeded,
  output logic              hasResult,
  output logic              remLast,
  output logic              resDone,
  output logic              nonDma,
  output logic              cmdStarted,
  output logic [BYTE_W-1:0] resByte
);
  localparam int IDX_W = 2;

  logic [BYTE_W-1:0] opcodeQ, param1Q, param2Q, remQ;
  logic [IDX_W-1:0]  byteIdxQ, resIdxQ;
  logic              nonDmaQ;
  cmd_info_t         info;

  assign info = decodeOp(opcodeQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opcodeQ  <= '0;
      param1Q  <= '0;
      param2Q  <= '0;
      remQ     <= '0;
      byteIdxQ <= '0;
      resIdxQ  <= '0;
      nonDmaQ  <= 1'b1;
    end else begin
      if (stb.capByte) begin
        byteIdxQ <= byteIdxQ + 1'b1;
        case (byteIdxQ)
          2'd0: begin opcodeQ <= wrData; param1Q <= '0; param2Q <= '0; end
          2'd1: param1Q <= wrData;
          default: param2Q <= wrData;
        endcase
      end
      if (stb.cmdDone) begin
        byteIdxQ <= '0;
        resIdxQ  <= '0;
        remQ     <= param2Q;
        if (info.isMode) nonDmaQ <= param2Q[0];
      end
      if (stb.decRem) remQ    <= remQ - 1'b1;
      if (stb.resAdv) resIdxQ <= resIdxQ + 1'b1;
    end
  end

  assign allIn      = byteIdxQ == (info.nParams + 2'd1);
  assign execNeeded = info.hasExec && (param2Q != '0);
  assign hasResult  = info.resLen != 2'd0;
  assign remLast    = remQ == BYTE_W'(1);
  assign resDone    = resIdxQ == info.resLen;
  assign nonDma     = nonDmaQ;
  assign cmdStarted = byteIdxQ != '0;

  always_comb begin
    case (resIdxQ)
      2'd0:    resByte = info.valid ? opcodeQ : BAD_OP_RES;
      2'd1:    resByte = info.isSense ? {{(BYTE_W-1){1'b0}}, nonDmaQ} : param1Q;
      default: resByte = param2Q;
    endcase
  end
endmodule

// File: rtl/hseq_ctrl.sv
module hseq_ctrl
  import hseq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    hostWrEn,
  input  logic    hostRdEn,
  input  logic    xferAck,
  input  logic    allIn,
  input  logic    execNeeded,
  input  logic    hasResult,
  input  logic    remLast,
  input  logic    resDone,
  input  logic    nonDma,
  input  logic    cmdStarted,
  output strobe_t stb,
  output logic    rdValid,
  output logic [BYTE_W-1:0] statusOut,
  output logic    irqOut,
  output logic    dmaReqOut
);
  phase_e state, nextState;
  logic rqm, dio, exe, busy;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_CMD;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    stb       = '0;
    case (state)
      S_CMD: if (hostWrEn) begin
        stb.capByte = 1'b1;
        nextState   = S_CMD_GAP;
      end
      S_CMD_GAP: if (!allIn) nextState = S_CMD;
      else begin
        stb.cmdDone = 1'b1;
        if (execNeeded)     nextState = S_EXEC;
        else if (hasResult) nextState = S_RES;
        else                nextState = S_CMD;
      end
      S_EXEC: if (xferAck) begin
        stb.decRem = 1'b1;
        if (remLast) nextState = hasResult ? S_RES : S_CMD;
      end
      S_RES: if (hostRdEn) begin
        stb.resAdv = 1'b1;
        nextState  = S_RES_GAP;
      end
      S_RES_GAP: nextState = resDone ? S_CMD : S_RES;
      default:   nextState = S_CMD;
    endcase
  end

  assign rqm       = (state == S_CMD) || (state == S_RES);
  assign dio       = (state == S_RES) || (state == S_RES_GAP);
  assign exe       = state == S_EXEC;
  assign busy      = !((state == S_CMD) && !cmdStarted);
  assign rdValid   = state == S_RES;
  assign statusOut = {rqm, dio, exe, busy, 4'b0000};
  assign irqOut    = exe && nonDma;
  assign dmaReqOut = exe && !nonDma;
endmodule

// File: rtl/host_cmd_sequencer.sv
module host_cmd_sequencer
  import hseq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic [BYTE_W-1:0] hostWrData,
  input  logic              hostRdEn,
  output logic [BYTE_W-1:0] hostRdData,
  output logic [BYTE_W-1:0] statusOut,
  output logic              irqOut,
  output logic              dmaReqOut,
  input  logic              xferAck
);
  strobe_t           stb;
  logic              allIn, execNeeded, hasResult, remLast, resDone, nonDma, cmdStarted, rdValid;
  logic [BYTE_W-1:0] resByte;

  hseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn), .xferAck(xferAck),
    .allIn(allIn), .execNeeded(execNeeded), .hasResult(hasResult), .remLast(remLast),
    .resDone(resDone), .nonDma(nonDma), .cmdStarted(cmdStarted), .stb(stb),
    .rdValid(rdValid), .statusOut(statusOut), .irqOut(irqOut), .dmaReqOut(dmaReqOut)
  );

  hseq_dpath u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(hostWrData),
    .allIn(allIn), .execNeeded(execNeeded), .hasResult(hasResult), .remLast(remLast),
    .resDone(resDone), .nonDma(nonDma), .cmdStarted(cmdStarted), .resByte(resByte)
  );

  assign hostRdData = rdValid ? resByte : '0;
endmodule

// File: rtl/host_cmd_sequencer_chk.sv
module host_cmd_sequencer_chk (
  input logic       clk,
  input logic       rstN,
  input logic       hostWrEn,
  input logic       hostRdEn,
  input logic [7:0] hostRdData,
  input logic [7:0] statusOut,
  input logic       irqOut,
  input logic       dmaReqOut
);
  AST_RQM_DROP_AFTER_WR: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && statusOut[7] && !statusOut[6]) |=> !statusOut[7]); // R3
  AST_RQM_DROP_AFTER_RD: assert property (@(posedge clk) disable iff (!rstN)
    (hostRdEn && statusOut[7] && statusOut[6]) |=> !statusOut[7]); // R8
  AST_ONE_REQ_LINE: assert property (@(posedge clk) disable iff (!rstN)
    !(irqOut && dmaReqOut)); // R6
  AST_REQ_ONLY_IN_EXEC: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut || dmaReqOut) |-> (statusOut[5] && !statusOut[7])); // R6
  AST_BUSY_IN_EXEC: assert property (@(posedge clk) disable iff (!rstN)
    statusOut[5] |-> statusOut[4]); // R10
  AST_WR_IN_RESULT_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && statusOut[7] && statusOut[6] && !hostRdEn) |=> $stable(statusOut)); // R11
  AST_RD_BUS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !(statusOut[7] && statusOut[6]) |-> (hostRdData == 8'h00)); // R11
endmodule

bind host_cmd_sequencer host_cmd_sequencer_chk u_chk (
  .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
  .hostRdData(hostRdData), .statusOut(statusOut), .irqOut(irqOut), .dmaReqOut(dmaReqOut)
);

// File: tb/host_cmd_sequencer_bench.sv
module host_cmd_sequencer_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostWrEn = 1'b0;
  logic [7:0] hostWrData = 8'h00;
  logic hostRdEn = 1'b0;
  logic [7:0] hostRdData, statusOut;
  logic irqOut, dmaReqOut;
  logic xferAck = 1'b0;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [7:0] expQ[$];
  int  execSeen = 0;
  bit  expIrqMode = 1'b1;
  bit  holdRes = 1'b0;
  bit  holdExec = 1'b0;

  always #4 clk = ~clk;

  host_cmd_sequencer u_host_cmd_sequencer (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostWrData(hostWrData),
    .hostRdEn(hostRdEn), .hostRdData(hostRdData), .statusOut(statusOut),
    .irqOut(irqOut), .dmaReqOut(dmaReqOut), .xferAck(xferAck)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  // monitor: serves result reads and execution requests, compares against scoreboard
  always @(negedge clk) begin
    if (rstN && statusOut[7] && statusOut[6] && !holdRes) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R8 unexpected result byte", hostRdData, 0);
      end else begin
        logic [7:0] e;
        e = expQ.pop_front();
        check(hostRdData == e, "R8/R4/R12 result byte", hostRdData, e);
      end
      hostRdEn <= 1'b1;
    end else begin
      hostRdEn <= 1'b0;
    end
    if (rstN && (irqOut || dmaReqOut) && !holdExec) begin
      check(irqOut == expIrqMode && dmaReqOut == !expIrqMode, "R7 request line",
            {irqOut, dmaReqOut}, {expIrqMode, !expIrqMode});
      execSeen++;
      xferAck <= 1'b1;
    end else begin
      xferAck <= 1'b0;
    end
  end

  task automatic writeByte(input logic [7:0] b);
    int n = 0;
    while (!(statusOut[7] && !statusOut[6]) && n < 300) begin @(negedge clk); n++; end
    hostWrEn = 1'b1; hostWrData = b;
    @(negedge clk);
    hostWrEn = 1'b0;
    check(statusOut[7] == 1'b0 && statusOut[4] == 1'b1, "R3 ready low after byte", statusOut, 8'h10);
  endtask

  task automatic waitIdle(input int expExec);
    int n = 0;
    while (!(statusOut == 8'h80 && expQ.size() == 0) && n < 500) begin @(negedge clk); n++; end
    check(statusOut == 8'h80, "R9 back in command phase", statusOut, 8'h80);
    check(expQ.size() == 0, "R9 all results read", expQ.size(), 0);
    check(execSeen == expExec, "R6 execution byte count", execSeen, expExec);
    execSeen = 0;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(statusOut == 8'h80, "R1 reset status", statusOut, 8'h80);
    check(statusOut[3:0] == 4'h0, "R2 low status bits", statusOut[3:0], 0);
    check(hostRdData == 8'h00, "R11 read bus quiet", hostRdData, 0);

    // sense: mode bit shows interrupt mode after reset (R1, R4)
    expQ.push_back(8'h04); expQ.push_back(8'h01);
    writeByte(8'h04);
    waitIdle(0);

    // read, count 3, interrupt mode
    expIrqMode = 1'b1;
    writeByte(8'h06);
    @(negedge clk);
    check(statusOut == 8'h90, "R3 ready back for parameter", statusOut, 8'h90);
    writeByte(8'h5A);
    expQ.push_back(8'h06); expQ.push_back(8'h5A); expQ.push_back(8'h03);
    writeByte(8'h03);
    @(negedge clk);
    check(statusOut == 8'h30 && irqOut, "R5 execution entered by itself", statusOut, 8'h30);
    waitIdle(3);

    // mode command selects DMA (R7), no result (R4)
    writeByte(8'h03); writeByte(8'hFF); writeByte(8'h00);
    @(negedge clk);
    check(statusOut == 8'h80, "R10 busy clear after no-result command", statusOut, 8'h80);
    expIrqMode = 1'b0;
    expQ.push_back(8'h04); expQ.push_back(8'h00);
    writeByte(8'h04);
    waitIdle(0);

    // write, count 2, DMA; write during execution is ignored
    holdExec = 1'b1;
    writeByte(8'h05); writeByte(8'h11); writeByte(8'h02);
    @(negedge clk);
    check(dmaReqOut && !irqOut, "R7 DMA request line", {irqOut, dmaReqOut}, 2'b01);
    hostWrEn = 1'b1; hostWrData = 8'h06;
    @(negedge clk);
    hostWrEn = 1'b0;
    check(statusOut == 8'h30, "R11 write during execution ignored", statusOut, 8'h30);
    check(statusOut[4] == 1'b1, "R10 busy during execution", statusOut[4], 1);
    holdExec = 1'b0;
    waitIdle(2);

    // unknown opcode: single error byte
    expQ.push_back(8'h80);
    writeByte(8'h1F);
    waitIdle(0);

    // read with count 0 skips execution
    expQ.push_back(8'h06); expQ.push_back(8'h33); expQ.push_back(8'h00);
    writeByte(8'h06); writeByte(8'h33); writeByte(8'h00);
    waitIdle(0);

    // write during result phase ignored
    holdRes = 1'b1;
    writeByte(8'h04);
    begin
      int n = 0;
      while (!(statusOut[7] && statusOut[6]) && n < 50) begin @(negedge clk); n++; end
    end
    hostWrEn = 1'b1; hostWrData = 8'h06;
    @(negedge clk);
    hostWrEn = 1'b0;
    check(statusOut == 8'hD0, "R11 write during result ignored", statusOut, 8'hD0);
    check(hostRdData == 8'h04, "R8 result byte held", hostRdData, 8'h04);
    expQ.push_back(8'h04); expQ.push_back(8'h00);
    holdRes = 1'b0;
    waitIdle(0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule